// File: doc/BRIEF.md
# Split-Screen Line Address Generator

This block gives the display fetch engine of a raster controller the starting word address of every visible scan line. The visible area can be split into an upper and a lower image, and each image has its own base address in display memory. Software programs both bases, the number of lines given to the upper image and a per-line word stride through a byte-wide register port. An external timing generator supplies a frame-start strobe at the end of vertical blanking, a line-start strobe for each scan line and the number of lines that are physically shown.

When a line strobe falls inside the active region, the block emits that line's start address one cycle later, with a one-cycle valid pulse and a flag that tells which image the line belongs to. Inside an image, each line's address is the previous one plus the stride. The first line of the lower image restarts from that image's own base. The two bases may be in any order and may be equal. All settings are captured at frame start, so software can rewrite them at any time without tearing the frame on screen.

Top module: `splitLineAddrGen`

## Requirements
- R1: Register offsets on the byte port: 0/1 upper-image base low/high byte, 2/3 lower-image base low/high byte, 4 upper-image line count bits 7:0, 5 line count bits 9:8 taken from data bits 1:0 (data bits 7:2 are ignored), 6/7 stride low/high byte.
- R2: The first active line after a frame-start strobe outputs the upper-image base, with the screen flag at 0.
- R3: Each later line in the same image outputs the previous line address plus the stride.
- R4: Line number N (counting from 0 after frame start) equal to the upper-image line count outputs the lower-image base with no stride added and sets the screen flag to 1. All later lines of the frame keep the flag at 1.
- R5: When the line count is equal to or greater than the physical line count, every active line of the frame comes from the upper image.
- R6: A line count of zero makes every line of the frame come from the lower image, starting at its base.
- R7: Correct addresses result whether the lower-image base is below, above or equal to the upper-image base.
- R8: Register writes take effect at the next frame-start strobe, including a write made in the same cycle as the strobe. The current frame keeps the values that were captured earlier.
- R9: Line strobes beyond the physical line count produce no valid pulse and leave the address and flag unchanged.
- R10: A line strobe in the same cycle as a frame-start strobe is ignored. The next line strobe is line 0 of the new frame.
- R11: After reset the address is 0, valid is 0 and the screen flag is 0. No line is active until the first frame-start strobe.
- R12: Address arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write enable |
| regAddr | input | 4 | Register offset |
| regWrData | input | 8 | Register write data |
| frameStart | input | 1 | Frame-start strobe (end of vertical blanking) |
| lineStart | input | 1 | Scan-line strobe |
| physLines | input | 10 | Number of physically displayed lines |
| lineAddr | output | 16 | Start word address of the last active line |
| lineValid | output | 1 | One-cycle pulse: lineAddr was just updated |
| screen2Active | output | 1 | 1 when the last active line came from the lower image |

## Verification
Two pairs of events can share a cycle: a register write with the frame-start strobe, and a line strobe with the frame-start strobe. The bench drives each pair together on purpose.

For the first pair, it expects the frame that follows to use the old value and the frame after that to use the new one. For the second pair, it expects no valid pulse, and the next line strobe must produce the upper-image base again.

Random frames also place writes and idle gaps between line strobes. Each output is compared against a reference model that computes addresses from the captured settings.

// File: rtl/splitLinePkg.sv
package splitLinePkg;
  // Per-cycle command from the line sequencer to the address datapath.
  typedef struct packed {
    logic snap;       // capture register values (frame start)
    logic loadS1;     // first line of the upper image
    logic loadS2;     // first line of the lower image
    logic addStride;  // continuation line inside an image
    logic toScreen2;  // the line being issued belongs to the lower image
  } lineCmd_t;
endpackage

// File: rtl/splitRegBank.sv
module splitRegBank #(
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 10,
  parameter int STRIDE_W = 16,
  parameter int REG_AW   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [7:0]          regWrData,
  output logic [ADDR_W-1:0]   s1Base,
  output logic [ADDR_W-1:0]   s2Base,
  output logic [CNT_W-1:0]    s1Lines,
  output logic [STRIDE_W-1:0] stride
);
  localparam int AB     = ADDR_W / 8;
  localparam int SB     = STRIDE_W / 8;
  localparam int OFF_S1 = 0;
  localparam int OFF_S2 = AB;
  localparam int OFF_LN = 2 * AB;
  localparam int OFF_ST = 2 * AB + 2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Base  <= '0;
      s2Base  <= '0;
      s1Lines <= '0;
      stride  <= '0;
    end else if (regWe) begin
      for (int b = 0; b < AB; b++) begin
        if (regAddr == REG_AW'(OFF_S1 + b)) s1Base[b*8 +: 8] <= regWrData;
        if (regAddr == REG_AW'(OFF_S2 + b)) s2Base[b*8 +: 8] <= regWrData;
      end
      for (int b = 0; b < SB; b++) begin
        if (regAddr == REG_AW'(OFF_ST + b)) stride[b*8 +: 8] <= regWrData;
      end
      // R1: high count byte carries only the top bits; the rest are dropped
      if (regAddr == REG_AW'(OFF_LN))     s1Lines[7:0] <= regWrData;
      if (regAddr == REG_AW'(OFF_LN + 1)) s1Lines[CNT_W-1:8] <= regWrData[CNT_W-9:0];
    end
  end
endmodule

// File: rtl/splitLineSeq.sv
module splitLineSeq
  import splitLinePkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             lineStart,
  input  logic [CNT_W-1:0] s1Lines,
  input  logic [CNT_W-1:0] physLines,
  output lineCmd_t         cmd
);
  logic [CNT_W-1:0] lineCnt;
  logic [CNT_W-1:0] splitQ;
  logic [CNT_W-1:0] physQ;
  logic             active;

  // frame start wins over a coincident line strobe (R10)
  assign active = lineStart && !frameStart && (lineCnt < physQ);

  always_comb begin
    cmd           = '0;
    cmd.snap      = frameStart;
    cmd.loadS1    = active && (lineCnt == '0) && (splitQ != '0);
    cmd.loadS2    = active && (lineCnt == splitQ);
    cmd.addStride = active && !cmd.loadS1 && !cmd.loadS2;
    cmd.toScreen2 = active && (lineCnt >= splitQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCnt <= '0;
      splitQ  <= '0;
      physQ   <= '0;
    end else if (frameStart) begin
      lineCnt <= '0;
      splitQ  <= s1Lines;
      physQ   <= physLines;
    end else if (active) begin
      lineCnt <= lineCnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    lineCnt <= physQ); // R9

  AST_ONE_LINE_KIND: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.loadS1, cmd.loadS2, cmd.addStride})); // R4
endmodule

// File: rtl/splitAddrPath.sv
module splitAddrPath
  import splitLinePkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int STRIDE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  lineCmd_t            cmd,
  input  logic [ADDR_W-1:0]   s1Base,
  input  logic [ADDR_W-1:0]   s2Base,
  input  logic [STRIDE_W-1:0] stride,
  output logic [ADDR_W-1:0]   lineAddr,
  output logic                lineValid,
  output logic                screen2Active
);
  logic [ADDR_W-1:0]   s1BaseQ;
  logic [ADDR_W-1:0]   s2BaseQ;
  logic [STRIDE_W-1:0] strideQ;
  logic                anyLine;

  assign anyLine = cmd.loadS1 | cmd.loadS2 | cmd.addStride;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1BaseQ       <= '0;
      s2BaseQ       <= '0;
      strideQ       <= '0;
      lineAddr      <= '0;
      lineValid     <= 1'b0;
      screen2Active <= 1'b0;
    end else begin
      if (cmd.snap) begin
        s1BaseQ <= s1Base;
        s2BaseQ <= s2Base;
        strideQ <= stride;
      end
      if (cmd.loadS1)         lineAddr <= s1BaseQ;
      else if (cmd.loadS2)    lineAddr <= s2BaseQ;
      else if (cmd.addStride) lineAddr <= lineAddr + ADDR_W'(strideQ);
      if (anyLine) screen2Active <= cmd.toScreen2;
      lineValid <= anyLine;
    end
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !lineValid |-> $stable(lineAddr)); // R9

  AST_FLAG_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !lineValid |-> $stable(screen2Active)); // R9
endmodule

// File: rtl/splitLineAddrGen.sv
module splitLineAddrGen
  import splitLinePkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 10,
  parameter int STRIDE_W = 16,
  parameter int REG_AW   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [7:0]        regWrData,
  input  logic              frameStart,
  input  logic              lineStart,
  input  logic [CNT_W-1:0]  physLines,
  output logic [ADDR_W-1:0] lineAddr,
  output logic              lineValid,
  output logic              screen2Active
);
  logic [ADDR_W-1:0]   s1Base;
  logic [ADDR_W-1:0]   s2Base;
  logic [CNT_W-1:0]    s1Lines;
  logic [STRIDE_W-1:0] stride;
  lineCmd_t            cmd;

  splitRegBank #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STRIDE_W(STRIDE_W), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWrData(regWrData),
    .s1Base(s1Base), .s2Base(s2Base), .s1Lines(s1Lines), .stride(stride)
  );

  splitLineSeq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .lineStart(lineStart),
    .s1Lines(s1Lines), .physLines(physLines), .cmd(cmd)
  );

  splitAddrPath #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) u_path (
    .clk(clk), .rstN(rstN), .cmd(cmd), .s1Base(s1Base), .s2Base(s2Base), .stride(stride),
    .lineAddr(lineAddr), .lineValid(lineValid), .screen2Active(screen2Active)
  );

  AST_VALID_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    lineValid |-> ($past(lineStart) && !$past(frameStart))); // R10
endmodule

// File: tb/splitLineAddrGen_bench.sv
module splitLineAddrGen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic        frameStart = 1'b0;
  logic        lineStart = 1'b0;
  logic [9:0]  physLines = '0;
  logic [15:0] lineAddr;
  logic        lineValid;
  logic        screen2Active;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // reference model state
  logic [15:0] shS1, shS2, shSt, snS1, snS2, snSt;
  logic [9:0]  shLn, snLn, snPhys;
  int          lineN;
  logic [15:0] prevAddr;
  logic        prevFlag;

  always #(CLK_PERIOD/2) clk = ~clk;

  splitLineAddrGen u_splitLineAddrGen (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWrData(regWrData),
    .frameStart(frameStart), .lineStart(lineStart), .physLines(physLines),
    .lineAddr(lineAddr), .lineValid(lineValid), .screen2Active(screen2Active)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic void modelWrite(input logic [3:0] a, input logic [7:0] d);
    case (a)
      4'd0: shS1[7:0]  = d;
      4'd1: shS1[15:8] = d;
      4'd2: shS2[7:0]  = d;
      4'd3: shS2[15:8] = d;
      4'd4: shLn[7:0]  = d;
      4'd5: shLn[9:8]  = d[1:0];
      4'd6: shSt[7:0]  = d;
      4'd7: shSt[15:8] = d;
      default: ;
    endcase
  endfunction

  function automatic logic [15:0] expAddr(input int n);
    int unsigned v;
    if (n < int'(snLn)) v = int'(snS1) + n * int'(snSt);
    else v = int'(snS2) + (n - int'(snLn)) * int'(snSt);
    return v[15:0];
  endfunction

  function automatic string lineTag(input int n);
    if (n < int'(snLn)) return (n == 0) ? "R2" : "R3";
    if (n == int'(snLn)) return (snLn == 0) ? "R6" : "R4";
    return "R3";
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    regWe = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWe = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic setAll(input logic [15:0] b1, input logic [15:0] b2,
                        input logic [9:0] ln, input logic [15:0] st);
    wr(4'd0, b1[7:0]); wr(4'd1, b1[15:8]);
    wr(4'd2, b2[7:0]); wr(4'd3, b2[15:8]);
    wr(4'd4, ln[7:0]); wr(4'd5, {6'b0, ln[9:8]});
    wr(4'd6, st[7:0]); wr(4'd7, st[15:8]);
  endtask

  // frame strobe, optionally with a coincident line strobe or register write
  task automatic frame(input logic [9:0] phys, input bit withLine,
                       input bit withWr, input logic [3:0] a, input logic [7:0] d);
    physLines = phys; frameStart = 1'b1; lineStart = withLine;
    if (withWr) begin regWe = 1'b1; regAddr = a; regWrData = d; end
    snS1 = shS1; snS2 = shS2; snSt = shSt; snLn = shLn; snPhys = phys;
    @(negedge clk);
    frameStart = 1'b0; lineStart = 1'b0; regWe = 1'b0;
    if (withWr) modelWrite(a, d);
    lineN = 0;
    chk(lineValid == 1'b0, withLine ? "R10 no valid on shared strobe" : "R10 no valid at frame", lineValid, 0);
  endtask

  task automatic line(input string extra);
    lineStart = 1'b1;
    @(negedge clk);
    lineStart = 1'b0;
    if (lineN < int'(snPhys)) begin
      logic [15:0] ea;
      logic        ef;
      ea = expAddr(lineN);
      ef = (lineN >= int'(snLn));
      chk(lineValid == 1'b1, {lineTag(lineN), " valid ", extra}, lineValid, 1);
      chk(lineAddr == ea, {lineTag(lineN), " addr ", extra}, lineAddr, ea);
      chk(screen2Active == ef, {(ef ? "R4" : "R5"), " flag ", extra}, screen2Active, ef);
      prevAddr = ea; prevFlag = ef;
      lineN++;
    end else begin
      chk(lineValid == 1'b0, {"R9 no valid ", extra}, lineValid, 0);
      chk(lineAddr == prevAddr, {"R9 addr held ", extra}, lineAddr, prevAddr);
      chk(screen2Active == prevFlag, {"R9 flag held ", extra}, screen2Active, prevFlag);
    end
  endtask

  task automatic runLines(input int cnt, input string extra);
    for (int i = 0; i < cnt; i++) line(extra);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    shS1 = '0; shS2 = '0; shSt = '0; shLn = '0;
    snS1 = '0; snS2 = '0; snSt = '0; snLn = '0; snPhys = '0;
    lineN = 0; prevAddr = '0; prevFlag = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(lineAddr == 16'h0, "R11 reset addr", lineAddr, 0);
    chk(lineValid == 1'b0, "R11 reset valid", lineValid, 0);
    chk(screen2Active == 1'b0, "R11 reset flag", screen2Active, 0);
    line("R11 before first frame");

    // R1 R7: lower base below upper; count high byte upper bits ignored
    setAll(16'h1000, 16'h0200, 10'd0, 16'h0028);
    wr(4'd4, 8'h03); wr(4'd5, 8'hFC);
    chk(shLn == 10'd3, "R1 model count", shLn, 3);
    frame(10'd6, 0, 0, 4'd0, 8'h00);
    runLines(8, "R1 R7 split at 3");

    // R6: zero count
    setAll(16'h0400, 16'h2000, 10'd0, 16'h0010);
    frame(10'd4, 0, 0, 4'd0, 8'h00);
    runLines(5, "R6 zero count");

    // R5: count above physical lines
    setAll(16'h0100, 16'h8000, 10'd1000, 16'h0050);
    frame(10'd5, 0, 0, 4'd0, 8'h00);
    runLines(6, "R5 no switch");
    setAll(16'h0100, 16'h8000, 10'd5, 16'h0050);
    frame(10'd5, 0, 0, 4'd0, 8'h00);
    runLines(6, "R5 count equal phys");

    // R7: equal bases
    setAll(16'h3300, 16'h3300, 10'd2, 16'h0008);
    frame(10'd5, 0, 0, 4'd0, 8'h00);
    runLines(5, "R7 equal bases");

    // R12: wrap
    setAll(16'hFFF0, 16'hFFFF, 10'd3, 16'h0010);
    frame(10'd6, 0, 0, 4'd0, 8'h00);
    runLines(6, "R12 wrap");

    // R8: mid-frame write and write coinciding with frame start
    setAll(16'h0A00, 16'h0B00, 10'd4, 16'h0004);
    frame(10'd8, 0, 0, 4'd0, 8'h00);
    runLines(2, "R8 before write");
    wr(4'd1, 8'h5A); wr(4'd4, 8'h01);
    runLines(6, "R8 after mid-frame write");
    frame(10'd4, 0, 1, 4'd3, 8'h77);
    runLines(4, "R8 write at frame start");
    frame(10'd4, 0, 0, 4'd0, 8'h00);
    runLines(4, "R8 coincident write applied");

    // R10: line strobe together with frame start
    runLines(1, "R10 old frame over");
    frame(10'd3, 1, 0, 4'd0, 8'h00);
    runLines(3, "R10 line 0 after shared strobe");

    // random frames
    for (int f = 0; f < 40; f++) begin
      logic [9:0] ph;
      int extraLines;
      if (($urandom % 3) == 0) setAll(16'($urandom), 16'($urandom),
                                       10'($urandom % 48), 16'($urandom % 512));
      ph = 10'(1 + $urandom % 40);
      frame(ph, ($urandom % 5) == 0, ($urandom % 4) == 0,
            4'($urandom % 8), 8'($urandom));
      extraLines = int'(ph) + int'($urandom % 4);
      for (int i = 0; i < extraLines; i++) begin
        if (($urandom % 6) == 0) wr(4'($urandom % 8), 8'($urandom));
        if (($urandom % 4) == 0) @(negedge clk);
        line("random");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule